// File: doc/BRIEF.md
# Reverse Supply Short-Circuit Protector

This block guards a reverse supply mode, where the battery feeds an external accessory back through the charge path. Software turns the mode on with an enable bit. While the mode is on, the block looks at a stream of signed accessory-path current samples, one per measurement tick. A positive sample means current is flowing out to the accessory.

Two overcurrent detectors run in parallel. A low-threshold detector needs a long run of samples above its limit before it acts. A high-threshold detector acts after a short run. A third detector looks for current flowing back from the accessory that is larger than a programmable limit.

When any detector qualifies, the block turns the path off and keeps it off. It records which detector fired and emits a single-cycle interrupt pulse. Overcurrent faults share one short-circuit interrupt. Reversal has its own interrupt. To recover, software drops the enable bit, which clears the record, and then sets the bit again.

Top module: `rev_supply_guard`

## Requirements
- R1: `path_en` is high exactly when `mode_en` is high and no trip is held. After reset no trip is held.
- R2: A valid sample with `sample_ma` >= SLOW_MA (default 500) counts toward the slow detector. The slow detector trips on the SLOW_US/TICK_US-th such sample in an unbroken run (default 1000/10 = 100).
- R3: A valid sample with `sample_ma` >= FAST_MA (default 1840) counts toward the fast detector. The fast detector trips on the FAST_US/TICK_US-th such sample in an unbroken run (default 100/10 = 10).
- R4: A valid sample below a detector's limit restarts that detector's run from zero.
- R5: On an overcurrent trip, `path_en` is low from the clock edge that takes the tripping sample. `short_irq` is high for exactly the cycle after that edge.
- R6: A reversal trip happens when −`sample_ma` is strictly greater than `rev_thresh_ma` (unsigned, mA) on two consecutive valid samples. It turns the path off with the same timing as R5 and pulses `rev_irq` instead of `short_irq`.
- R7: `trip_status` bit 0 is the slow trip, bit 1 the fast trip and bit 2 the reversal. The bits are set by trips and held while `mode_en` stays high. They are cleared, and the trip released, at the first clock edge with `mode_en` low.
- R8: Each interrupt is a one-cycle pulse. If the slow and fast detectors trip on the same sample, only one `short_irq` pulse is issued and both bits 0 and 1 are set.
- R9: Cycles with `sample_vld` low leave every detector's progress unchanged. While the path is inactive, all progress is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Software reverse-mode enable bit |
| sample_vld | input | 1 | A new current sample is present this cycle (one per tick) |
| sample_ma | input | 16 | Signed accessory current in mA, positive outbound |
| rev_thresh_ma | input | 16 | Unsigned reversal limit in mA |
| path_en | output | 1 | Accessory path enable |
| short_irq | output | 1 | Short-circuit interrupt pulse |
| rev_irq | output | 1 | Reversal interrupt pulse |
| trip_status | output | 3 | Held trip cause: {reverse, fast, slow} |

## Verification
The bench drives runs that stop one sample short of each debounce length. A detector that is off by one would trip early or one sample late. It inserts a single sub-limit sample and idle ticks into a run, which catches a counter that fails to restart or that counts idle cycles. It lines up slow and fast trips on the same sample to expose a doubled interrupt. It probes a reverse current exactly equal to the limit, and non-consecutive reverse samples, to catch a detector that uses >= or forgets its history. Random traffic with occasional enable drops checks that the trip is released and the cause is cleared.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned CUR_W = 16;
  localparam int unsigned ST_W  = 3;

  typedef logic signed [CUR_W-1:0] cur_t;

  // index of each cause in the held status word
  localparam int unsigned ST_SLOW = 0;
  localparam int unsigned ST_FAST = 1;
  localparam int unsigned ST_REV  = 2;

  // number of ticks a debounce window spans, never below one
  function automatic int unsigned ticks_for(int unsigned win_us, int unsigned tick_us);
    int unsigned n;
    n = win_us / tick_us;
    return (n == 0) ? 1 : n;
  endfunction

  // outbound current at or beyond a limit
  function automatic logic at_or_above(cur_t s, int lim_ma);
    return int'(s) >= lim_ma;
  endfunction

  // inbound current strictly beyond an unsigned limit
  function automatic logic inbound_excess(cur_t s, logic [CUR_W-1:0] lim_ma);
    return (-int'(s)) > int'(lim_ma);
  endfunction
endpackage

// File: rtl/rsg_debounce.sv
module rsg_debounce import rsg_pkg::*; #(
  parameter int          LIMIT_MA = 500,
  parameter int unsigned COUNT    = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  cur_t sample,
  output logic trip
);
  localparam int unsigned CW = $clog2(COUNT + 1);

  logic [CW-1:0] run_q;
  logic          hit;
  logic          last;

  assign hit  = at_or_above(sample, LIMIT_MA);
  assign last = (run_q == CW'(COUNT - 1));
  assign trip = active & tick & hit & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (!active)
      run_q <= '0;
    else if (tick) begin
      if (!hit || last)
        run_q <= '0;
      else
        run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsg_reverse_det.sv
module rsg_reverse_det import rsg_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  cur_t             sample,
  input  logic [CUR_W-1:0] limit_ma,
  output logic             trip
);
  logic prev_q;
  logic over;

  assign over = inbound_excess(sample, limit_ma);
  assign trip = active & tick & over & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prev_q <= 1'b0;
    else if (!active)
      prev_q <= 1'b0;
    else if (tick)
      prev_q <= over;
  end
endmodule

// File: rtl/rsg_trip_hold.sv
module rsg_trip_hold import rsg_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_en,
  input  logic            slow_evt,
  input  logic            fast_evt,
  input  logic            rev_evt,
  output logic            held,
  output logic [ST_W-1:0] cause,
  output logic            short_irq,
  output logic            rev_irq
);
  logic [ST_W-1:0] new_cause;

  always_comb begin
    new_cause          = '0;
    new_cause[ST_SLOW] = slow_evt;
    new_cause[ST_FAST] = fast_evt;
    new_cause[ST_REV]  = rev_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      cause     <= '0;
      short_irq <= 1'b0;
      rev_irq   <= 1'b0;
    end else begin
      short_irq <= slow_evt | fast_evt;
      rev_irq   <= rev_evt;
      if (!mode_en) begin
        held  <= 1'b0;
        cause <= '0;
      end else begin
        held  <= held | (|new_cause);
        cause <= cause | new_cause;
      end
    end
  end
endmodule

// File: rtl/rev_supply_guard.sv
module rev_supply_guard import rsg_pkg::*; #(
  parameter int unsigned SLOW_MA = 500,
  parameter int unsigned FAST_MA = 1840,
  parameter int unsigned SLOW_US = 1000,
  parameter int unsigned FAST_US = 100,
  parameter int unsigned TICK_US = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_en,
  input  logic                    sample_vld,
  input  logic signed [CUR_W-1:0] sample_ma,
  input  logic        [CUR_W-1:0] rev_thresh_ma,
  output logic                    path_en,
  output logic                    short_irq,
  output logic                    rev_irq,
  output logic        [ST_W-1:0]  trip_status
);
  localparam int unsigned SLOW_CNT = ticks_for(SLOW_US, TICK_US);
  localparam int unsigned FAST_CNT = ticks_for(FAST_US, TICK_US);

  function automatic int lim_of(int g);
    return (g == 0) ? int'(SLOW_MA) : int'(FAST_MA);
  endfunction

  function automatic int unsigned cnt_of(int g);
    return (g == 0) ? SLOW_CNT : FAST_CNT;
  endfunction

  logic       held;
  logic       active;
  logic [1:0] oc_trip;
  logic       slow_evt;
  logic       fast_evt;
  logic       rev_evt;

  assign active = mode_en & ~held;
  assign path_en = active;

  for (genvar g = 0; g < 2; g++) begin : g_oc
    rsg_debounce #(
      .LIMIT_MA(lim_of(g)),
      .COUNT   (cnt_of(g))
    ) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .active(active),
      .tick  (sample_vld),
      .sample(sample_ma),
      .trip  (oc_trip[g])
    );
  end

  assign slow_evt = oc_trip[0];
  assign fast_evt = oc_trip[1];

  rsg_reverse_det u_rev (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .tick    (sample_vld),
    .sample  (sample_ma),
    .limit_ma(rev_thresh_ma),
    .trip    (rev_evt)
  );

  rsg_trip_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_en  (mode_en),
    .slow_evt (slow_evt),
    .fast_evt (fast_evt),
    .rev_evt  (rev_evt),
    .held     (held),
    .cause    (trip_status),
    .short_irq(short_irq),
    .rev_irq  (rev_irq)
  );
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_en,
  input logic       path_en,
  input logic       short_irq,
  input logic       rev_irq,
  input logic [2:0] trip_status,
  input logic       slow_evt,
  input logic       fast_evt,
  input logic       rev_evt
);
  AST_PATH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    path_en |-> mode_en); // R1
  AST_EVT_NEEDS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_evt || fast_evt || rev_evt) |-> path_en); // R1
  AST_OC_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_evt || fast_evt) |=> (short_irq && !path_en)); // R5
  AST_SHORT_PATH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    short_irq |-> !path_en); // R5
  AST_REV_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rev_evt |=> (rev_irq && !path_en)); // R6
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (trip_status == 3'b000)); // R7
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && trip_status != 3'b000) ##1 mode_en |-> $stable(trip_status)); // R7
  AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    short_irq |=> !short_irq); // R8
  AST_REV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rev_irq |=> !rev_irq); // R8
endmodule

bind rev_supply_guard rsg_checker u_rsg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_en    (mode_en),
  .path_en    (path_en),
  .short_irq  (short_irq),
  .rev_irq    (rev_irq),
  .trip_status(trip_status),
  .slow_evt   (slow_evt),
  .fast_evt   (fast_evt),
  .rev_evt    (rev_evt)
);

// File: tb/test_rev_supply_guard.sv
module test_rev_supply_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_MA = 500;
  localparam int FAST_MA = 1840;
  localparam int SLOW_N  = 8;   // 80 us / 10 us
  localparam int FAST_N  = 3;   // 30 us / 10 us

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0;
  logic        sample_vld = 1'b0;
  logic signed [15:0] sample_ma = '0;
  logic [15:0] rev_thresh_ma = 16'd100;
  logic        path_en;
  logic        short_irq;
  logic        rev_irq;
  logic [2:0]  trip_status;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state
  int   m_slow = 0;
  int   m_fast = 0;
  bit   m_prev = 0;
  bit   m_held = 0;
  logic [2:0] m_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rev_supply_guard #(
    .SLOW_MA(SLOW_MA), .FAST_MA(FAST_MA),
    .SLOW_US(80), .FAST_US(30), .TICK_US(10)
  ) i_rev_supply_guard (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .sample_vld(sample_vld),
    .sample_ma(sample_ma), .rev_thresh_ma(rev_thresh_ma), .path_en(path_en),
    .short_irq(short_irq), .rev_irq(rev_irq), .trip_status(trip_status)
  );

  function automatic bit over_lim(int s, int lim);
    return s >= lim;
  endfunction

  function automatic bit back_flow(int s, int lim);
    return (0 - s) > lim;
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s {path,short,rev,status} got=%b exp=%b", tag, got, exp);
    end
  endtask

  // called just after a falling edge; drives one cycle and checks its outcome
  task automatic step(input bit en, input bit vld, input int s, input string tag);
    bit act, hs, hf, hr, se, fe, re;
    mode_en = en;
    sample_vld = vld;
    sample_ma = 16'(s);
    act = en && !m_held;
    hs = over_lim(s, SLOW_MA);
    hf = over_lim(s, FAST_MA);
    hr = back_flow(s, int'(rev_thresh_ma));
    se = act && vld && hs && (m_slow == SLOW_N - 1);
    fe = act && vld && hf && (m_fast == FAST_N - 1);
    re = act && vld && hr && m_prev;
    if (!act) begin
      m_slow = 0; m_fast = 0; m_prev = 0;
    end else if (vld) begin
      m_slow = (hs && !se) ? m_slow + 1 : 0;
      m_fast = (hf && !fe) ? m_fast + 1 : 0;
      m_prev = hr;
    end
    if (!en) begin
      m_held = 0; m_stat = '0;
    end else begin
      m_held = m_held || se || fe || re;
      m_stat = m_stat | {re, fe, se};
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, {path_en, short_irq, rev_irq, trip_status},
          {en && !m_held, se || fe, re, m_stat});
  endtask

  task automatic run(input int n, input int s, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, s, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {path_en, short_irq, rev_irq, trip_status}, 6'b000000);
    step(1'b1, 1'b0, 0, "R1 enable");

    // R2: one short of the slow window, then the tripping sample
    run(SLOW_N - 1, 600, "R2 slow run below count");
    step(1'b1, 1'b1, 600, "R2 slow trip");
    step(1'b1, 1'b1, 0, "R5 path held off");
    step(1'b0, 1'b0, 0, "R7 clear on enable low");
    step(1'b1, 1'b0, 0, "R7 re-enable");

    // R4 / R9: a sub-limit sample restarts, idle ticks do not
    run(SLOW_N - 1, SLOW_MA, "R4 run at exact limit");
    step(1'b1, 1'b1, SLOW_MA - 1, "R4 break run");
    run(SLOW_N - 2, 700, "R4 restarted run");
    step(1'b1, 1'b0, 0, "R9 idle tick");
    step(1'b1, 1'b0, 5000, "R9 idle with large sample");
    step(1'b1, 1'b1, 700, "R9 run continues");
    step(1'b1, 1'b1, 700, "R2 trip after idle");
    step(1'b0, 1'b0, 0, "R7 clear");

    // R9: enable low restarts the run
    run(SLOW_N - 1, 900, "R9 partial run");
    step(1'b0, 1'b1, 900, "R9 enable drop");
    run(SLOW_N - 1, 900, "R9 run from zero");
    step(1'b0, 1'b0, 0, "R9 clear");

    // R3: fast detector
    run(FAST_N - 1, FAST_MA, "R3 fast run");
    step(1'b1, 1'b1, FAST_MA - 1, "R3 fast break");
    run(FAST_N, 2000, "R3 fast trip");
    step(1'b0, 1'b0, 0, "R7 clear");

    // R8: slow and fast trip on the same sample
    run(SLOW_N - FAST_N, 600, "R8 slow lead");
    run(FAST_N, 2500, "R8 joint trip");
    step(1'b1, 1'b0, 0, "R8 single pulse");
    step(1'b0, 1'b0, 0, "R7 clear");

    // R6: reversal
    rev_thresh_ma = 16'd100;
    run(3, -100, "R6 equal to limit");
    step(1'b1, 1'b1, -101, "R6 first over");
    step(1'b1, 1'b1, 50, "R6 gap");
    step(1'b1, 1'b1, -101, "R6 restart");
    step(1'b1, 1'b0, 0, "R9 idle keeps reverse history");
    step(1'b1, 1'b1, -300, "R6 reverse trip");
    step(1'b1, 1'b1, 3000, "R5 held off ignores samples");
    step(1'b0, 1'b0, 0, "R7 clear");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int  k;
      int  s;
      bit  en;
      bit  vld;
      k = int'($urandom % 7);
      case (k)
        0: s = int'($urandom % 500);
        1: s = 500 + int'($urandom % 1340);
        2: s = 1840 + int'($urandom % 2000);
        3: s = 0 - int'($urandom % 400);
        4: s = ($urandom % 2 == 0) ? SLOW_MA : FAST_MA;
        5: s = 0 - int'(rev_thresh_ma) - int'($urandom % 2);
        default: s = 600 + int'($urandom % 1500);
      endcase
      en  = ($urandom % 30) != 0;
      vld = ($urandom % 4) != 0;
      if ($urandom % 200 == 0) rev_thresh_ma = 16'($urandom % 300);
      step(en, vld, s, "R5 R6 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule